// File: doc/BRIEF.md
# One-Bit Speaker to PCM Sample Stretcher

This block sits between an emulated home computer's one-bit speaker output and an 8-bit DAC. The emulated program only runs during video blanking, so its speaker writes come in bursts. The block evens them out into a steady sample stream paced by the video line tick. During blanking, every line tick records the most recent speaker bit in a circular buffer, together with a flag that says whether any write happened since the previous tick. On every line tick, blanking or not, the output side takes one buffered entry and updates an 8-bit level. Each entry is used for four consecutive ticks before the next one is taken, which stretches the captured sound in time by a factor of four.

An entry that carries a fresh write drives the level to full scale (bit 1) or to zero (bit 0). An entry with no write moves the level a fixed step toward mid-scale, 0x80, and never past it. A tone therefore ends by gliding back to the rest level, and the output carries no DC offset. When the buffer is empty the level holds.

Top module: `beeper_pcm_stretch`

## Requirements
- R1: While the asynchronous active-low reset is applied, and after it is released, the output is 0x80, the buffer is empty and no write is pending.
- R2: On a cycle with line_tick high and blank high, one entry is appended to the buffer. The entry holds a written flag (any spk_wr since the previous line tick) and the latest speaker bit. A line tick with blank low appends nothing.
- R3: The captured bit is the value of the last spk_wr before the tick. A spk_wr in the same cycle as a line tick is not part of that tick's entry. It counts toward the next tick's entry. Every line tick clears the written flag.
- R4: pcm_out changes only in the clock edge that ends a line_tick cycle. A speaker write without a tick leaves it unchanged.
- R5: On each line tick with a non-empty buffer, the oldest entry is applied. Each entry is applied on four consecutive such ticks and then removed. Entries are removed in the order they were appended. A tick that both appends and removes applies only the entries present before it.
- R6: An applied entry whose written flag is set drives pcm_out to 0xFF when its bit is 1, and to 0x00 when its bit is 0.
- R7: An applied entry whose written flag is clear moves pcm_out toward 0x80 by STEP (default 4). When the remaining distance is at most STEP, pcm_out lands exactly on 0x80. At 0x80 it stays.
- R8: A line tick with an empty buffer leaves pcm_out unchanged and removes nothing.
- R9: The buffer holds 256 entries. A capture that arrives when the buffer is full is dropped, and the stored entries are kept unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_tick | input | 1 | One-cycle pulse per video line |
| blank | input | 1 | High while the emulated program runs (vertical blanking) |
| spk_wr | input | 1 | Strobe: write to the speaker port this cycle |
| spk_bit | input | 1 | Speaker bit carried by the write |
| pcm_out | output | 8 | Sample level for the DAC |

## Verification
The bench sweeps all sixteen 4-bit tone patterns through the buffer. This separates the replay count and the entry order from plain level mapping, because any repeat count other than four shifts where the 0x00 and 0xFF edges appear. Long silent stretches starting from 0xFF and from 0x00 check the decay slope and the exact clamp at 0x80 from both sides. A stretch from 0xFF must stop at 0x83 and then jump to 0x80 rather than overshoot. Writes outside blanking, repeated writes before one tick, and a write coinciding with a tick tell apart the three capture-timing rules. A 400-tick burst against a slower drain fills the buffer. The long drain that follows shows that entries arriving when the buffer is full are dropped and not overwritten.

// File: rtl/bpcm_pkg.sv
package bpcm_pkg;
  // One buffered capture: was the port written since the last tick, and its bit
  typedef struct packed {
    logic written;
    logic level_hi;
  } bpcm_smp_t;
endpackage

// File: rtl/bpcm_rst_sync.sv
module bpcm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/bpcm_capture.sv
module bpcm_capture
  import bpcm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      line_tick,
  input  logic      spk_wr,
  input  logic      spk_bit,
  output bpcm_smp_t cap
);
  logic spk_q, spk_d;
  logic wr_q, wr_d;

  // Next state: a write wins over the tick clear, so it counts for the next tick
  always_comb begin
    spk_d = spk_q;
    wr_d  = wr_q;
    if (line_tick) wr_d = 1'b0;
    if (spk_wr) begin
      spk_d = spk_bit;
      wr_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spk_q <= 1'b0;
      wr_q  <= 1'b0;
    end else begin
      spk_q <= spk_d;
      wr_q  <= wr_d;
    end
  end

  assign cap.written  = wr_q;
  assign cap.level_hi = spk_q;
endmodule

// File: rtl/bpcm_ring.sv
module bpcm_ring
  import bpcm_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  bpcm_smp_t   wdata,
  input  logic        pop,
  output bpcm_smp_t   rdata,
  output logic        empty,
  output logic        full,
  output logic [AW:0] fill
);
  localparam int DEPTH = 1 << AW;

  bpcm_smp_t   mem [DEPTH];
  logic [AW:0] wr_q, wr_d, rd_q, rd_d;
  logic        push_ok, pop_ok;

  assign fill    = wr_q - rd_q;
  assign empty   = (wr_q == rd_q);
  assign full    = (fill == (AW+1)'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rd_q[AW-1:0]];

  always_comb begin
    wr_d = wr_q;
    rd_d = rd_q;
    if (push_ok) wr_d = wr_q + 1'b1;
    if (pop_ok)  rd_d = rd_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  // Storage: no reset, written only under its enable
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q[AW-1:0]] <= wdata;
  end
endmodule

// File: rtl/bpcm_level.sv
module bpcm_level
  import bpcm_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int STRETCH = 4,
  parameter int STEP    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_tick,
  input  logic              empty,
  input  bpcm_smp_t         head,
  output logic              pop,
  output logic [DATA_W-1:0] level
);
  localparam int              REP_W = (STRETCH > 1) ? $clog2(STRETCH) : 1;
  localparam logic [DATA_W-1:0] MID  = DATA_W'(1) << (DATA_W-1);
  localparam logic [DATA_W-1:0] STP  = DATA_W'(STEP);
  localparam logic [REP_W-1:0]  LAST = REP_W'(STRETCH-1);

  logic [REP_W-1:0]  rep_q, rep_d;
  logic [DATA_W-1:0] lvl_q, lvl_d, decayed;

  // Move one step toward mid-scale without crossing it
  always_comb begin
    decayed = lvl_q;
    if (lvl_q > MID)
      decayed = ((lvl_q - MID) > STP) ? (lvl_q - STP) : MID;
    else if (lvl_q < MID)
      decayed = ((MID - lvl_q) > STP) ? (lvl_q + STP) : MID;
  end

  always_comb begin
    rep_d = rep_q;
    lvl_d = lvl_q;
    pop   = 1'b0;
    if (line_tick && !empty) begin
      if (head.written) lvl_d = head.level_hi ? '1 : '0;
      else              lvl_d = decayed;
      if (rep_q == LAST) begin
        rep_d = '0;
        pop   = 1'b1;
      end else begin
        rep_d = rep_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rep_q <= '0;
      lvl_q <= MID;
    end else begin
      rep_q <= rep_d;
      lvl_q <= lvl_d;
    end
  end

  assign level = lvl_q;
endmodule

// File: rtl/beeper_pcm_stretch.sv
module beeper_pcm_stretch
  import bpcm_pkg::*;
#(
  parameter int AW      = 8,
  parameter int DATA_W  = 8,
  parameter int STRETCH = 4,
  parameter int STEP    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_tick,
  input  logic              blank,
  input  logic              spk_wr,
  input  logic              spk_bit,
  output logic [DATA_W-1:0] pcm_out
);
  logic        rst_q_n;
  bpcm_smp_t   cap, head;
  logic        fifo_empty, fifo_full, pop;
  logic [AW:0] fill_cnt;

  bpcm_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  bpcm_capture u_cap (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .line_tick (line_tick),
    .spk_wr    (spk_wr),
    .spk_bit   (spk_bit),
    .cap       (cap)
  );

  bpcm_ring #(.AW(AW)) u_ring (
    .clk   (clk),
    .rst_n (rst_q_n),
    .push  (line_tick && blank),
    .wdata (cap),
    .pop   (pop),
    .rdata (head),
    .empty (fifo_empty),
    .full  (fifo_full),
    .fill  (fill_cnt)
  );

  bpcm_level #(.DATA_W(DATA_W), .STRETCH(STRETCH), .STEP(STEP)) u_lvl (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .line_tick (line_tick),
    .empty     (fifo_empty),
    .head      (head),
    .pop       (pop),
    .level     (pcm_out)
  );
endmodule

// File: rtl/bpcm_chk.sv
module bpcm_chk #(
  parameter int AW     = 8,
  parameter int DATA_W = 8,
  parameter int STEP   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_tick,
  input logic              blank,
  input logic              fifo_empty,
  input logic [AW:0]       fill_cnt,
  input logic [DATA_W-1:0] pcm_out
);
  localparam int MID = 1 << (DATA_W-1);

  int unsigned dist_now;
  always_comb begin
    dist_now = (int'(pcm_out) >= MID) ? int'(pcm_out) - MID : MID - int'(pcm_out);
  end

  // R4
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_tick |=> $stable(pcm_out));

  // R8
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_tick && fifo_empty) |=> $stable(pcm_out));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= (AW+1)'(1 << AW));

  // R2
  grow_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt > $past(fill_cnt)) |-> $past(line_tick && blank));

  // R5
  shrink_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt < $past(fill_cnt)) |-> $past(line_tick && !fifo_empty));

  // R7
  decay_toward_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_tick |=> (pcm_out == '0 || pcm_out == '1 ||
                   (dist_now <= $past(dist_now) && $past(dist_now) - dist_now <= STEP)));
endmodule

bind beeper_pcm_stretch bpcm_chk #(.AW(AW), .DATA_W(DATA_W), .STEP(STEP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .line_tick  (line_tick),
  .blank      (blank),
  .fifo_empty (fifo_empty),
  .fill_cnt   (fill_cnt),
  .pcm_out    (pcm_out)
);

// File: tb/test_beeper_pcm_stretch.sv
`timescale 1ns/1ps
module test_beeper_pcm_stretch;
  localparam int STEP  = 4;
  localparam int REPS  = 4;
  localparam int DEPTH = 256;
  localparam int MID   = 128;

  logic       clk = 1'b0;
  logic       rst_n, line_tick, blank, spk_wr, spk_bit;
  logic [7:0] pcm_out;

  always #2.5 clk = ~clk;

  beeper_pcm_stretch i_beeper_pcm_stretch (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_tick (line_tick),
    .blank     (blank),
    .spk_wr    (spk_wr),
    .spk_bit   (spk_bit),
    .pcm_out   (pcm_out)
  );

  int       nvec = 0, nbad = 0;
  bit [1:0] mq[$];            // {written, bit}
  int       mlvl = MID, mrep = 0;
  bit       mwr = 0, mbit = 0;

  task automatic chk(string tag, int act, int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: pcm_out=%02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic int toward_mid(int v);
    if (v > MID) return (v - MID > STEP) ? v - STEP : MID;
    if (v < MID) return (MID - v > STEP) ? v + STEP : MID;
    return v;
  endfunction

  // Expected effect of one line tick, from the requirements
  task automatic model_tick(bit b);
    int pre = mq.size();
    if (pre > 0) begin
      mlvl = mq[0][1] ? (mq[0][0] ? 255 : 0) : toward_mid(mlvl);
      mrep++;
      if (mrep == REPS) begin
        void'(mq.pop_front());
        mrep = 0;
      end
    end
    if (b && pre < DEPTH) mq.push_back({mwr, mbit});
    mwr = 0;
  endtask

  task automatic tick(bit b, string tag);
    @(negedge clk); line_tick = 1'b1; blank = b;
    @(negedge clk); line_tick = 1'b0;
    model_tick(b);
    chk(tag, pcm_out, mlvl);
  endtask

  task automatic wr(bit v, string tag);
    @(negedge clk); spk_wr = 1'b1; spk_bit = v;
    @(negedge clk); spk_wr = 1'b0;
    mwr = 1; mbit = v;
    chk(tag, pcm_out, mlvl);
  endtask

  task automatic tick_wr(bit b, bit v, string tag);
    @(negedge clk); line_tick = 1'b1; blank = b; spk_wr = 1'b1; spk_bit = v;
    @(negedge clk); line_tick = 1'b0; spk_wr = 1'b0;
    model_tick(b);
    mwr = 1; mbit = v;
    chk(tag, pcm_out, mlvl);
  endtask

  task automatic drain(int n, string tag);
    repeat (n) tick(1'b0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nvec++; nbad++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; line_tick = 1'b0; blank = 1'b0; spk_wr = 1'b0; spk_bit = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", pcm_out, MID);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after reset", pcm_out, MID);

    drain(6, "R8 empty buffer holds");

    // Write outside blanking: nothing captured, output stays at rest
    wr(1'b1, "R4 write alone");
    tick(1'b0, "R2 no capture outside blank");
    drain(4, "R2 nothing buffered");
    drain(2, "R8 still empty");

    // All 4-bit tone patterns: level mapping, four-fold replay, order
    for (int p = 0; p < 16; p++) begin
      for (int i = 0; i < 4; i++) begin
        wr(p[i], "R4 write before tick");
        tick(1'b1, "R5 R6 tone capture");
      end
      drain(18, "R5 R6 tone replay");
    end

    // Capture timing: last write wins; a write with the tick is deferred
    wr(1'b1, "R3 first write");
    wr(1'b0, "R3 second write");
    tick(1'b1, "R3 latest bit");
    tick_wr(1'b1, 1'b1, "R3 write with tick deferred");
    tick(1'b1, "R3 deferred write captured");
    tick(1'b1, "R3 flag cleared");
    drain(24, "R3 replay");

    // Decay from full scale and from zero, including clamp at mid
    wr(1'b1, "R4 write before tone");
    tick(1'b1, "R6 high");
    repeat (40) tick(1'b1, "R7 silent capture high side");
    drain(180, "R7 decay from 0xFF");
    chk("R7 settled high side", pcm_out, MID);
    wr(1'b0, "R4 write before tone");
    tick(1'b1, "R6 low");
    repeat (40) tick(1'b1, "R7 silent capture low side");
    drain(180, "R7 decay from 0x00");
    chk("R7 settled low side", pcm_out, MID);

    // Overfill: capture faster than drain until full, then drain it all
    for (int k = 0; k < 400; k++) begin
      wr(k[0] ^ k[3], "R4 burst write");
      tick(1'b1, "R9 fill toward full");
    end
    drain(1100, "R9 drain after overflow");
    drain(4, "R8 empty after drain");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule